// File: doc/BRIEF.md
# Lane-Splittable Shift-and-Add Multiplier

This block is a bit-parallel integer multiplier of width `W` (16 by default). For each operation it can be treated as one wide lane or cut into several narrower lanes. A mode code selects the lane width: 2, 4, 8 or 16 bits. Every lane multiplies its own unsigned multiplicand slice by its own unsigned multiplier slice. All lanes work at the same time and share a single ripple adder. Where one lane meets the next, the adder's carry is forced to zero, so no carry crosses from one lane into its neighbour.

Each product is built by iterative add-and-shift, one multiplier bit per clock. The running partial sum and the not-yet-consumed multiplier bits are held in a double-width accumulator register pair between iterations. An n-bit lane therefore needs exactly n iterations, so latency grows linearly with the selected precision.

Operands enter through a valid/ready handshake. `in_ready` is high only while the unit is idle, and an operation starts on any clock edge where `in_valid` and `in_ready` are both high. The result leaves through a second valid/ready handshake. `out_valid` stays high and `product` stays frozen until the consumer raises `out_ready`. A new operation cannot start until that result has been taken, so back-pressure on the output stalls the input. `done` is a plain status pulse that marks the cycle in which a result first appears.

Top module: `simd_shiftadd_mul`

## Requirements
- R1: The mode code chooses the lane width n: 0 gives 2-bit lanes, 1 gives 4-bit lanes, 2 gives 8-bit lanes and 3 gives one 16-bit lane. Lane i of `a` and of `b` occupies bits [n*i +: n].
- R2: Lane i of `product` occupies bits [2n*i +: 2n]. It holds the unsigned product of lane i of `a` and lane i of `b`.
- R3: Carries never cross a lane boundary. Even with every lane at its maximum value (all ones times all ones), each lane's result equals its own product.
- R4: `out_valid` rises exactly n clock edges after the edge on which the operands were accepted, where n is the accepted lane width.
- R5: `done` is high for exactly one cycle per operation, in the first cycle that `out_valid` is high.
- R6: `in_ready` is high only while no operation is running and no result is waiting. Operands are accepted on an edge where `in_valid` and `in_ready` are both high.
- R7: `mode`, `a`, `b` and `in_valid` are ignored while `in_ready` is low. A mode change takes effect only at acceptance, when the unit is idle.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `product` does not change. After the edge on which `out_ready` is seen high, `out_valid` is low and `in_ready` is high.
- R9: After reset, `in_ready` is 1, and `out_valid`, `done` and `product` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Lane-width code (0:2, 1:4, 2:8, 3:16 bits), sampled at acceptance |
| in_valid | input | 1 | Operands and mode are valid |
| in_ready | output | 1 | Unit idle and able to accept operands |
| a | input | W | Multiplicand lanes |
| b | input | W | Multiplier lanes |
| out_ready | input | 1 | Consumer accepts the result |
| out_valid | output | 1 | `product` holds a finished result |
| product | output | 2W | Per-lane double-width products |
| done | output | 1 | One-cycle pulse when a result first becomes valid |

## Verification
The hardest situation to reach from the ports is a change on the mode and operand pins while a multiply is still running, or while a finished result is being held back by the consumer. Only the latched values may shape the latency and the result. To reach this, the bench drives fresh random values on `mode`, `a`, `b` and `in_valid` on every cycle after acceptance, and holds `out_ready` low for a random number of cycles. It then checks the latency and the product against the values that were accepted. Carries at every lane boundary are exercised by directed all-ones operands in each mode.

// File: rtl/smul_pkg.sv
`timescale 1ns/1ps
package smul_pkg;

  // Sequencer states for the iterative multiply.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } smul_state_e;

  // Lane width selected by a mode code, limited to the datapath width.
  function automatic int lane_width(input int code, input int n_modes);
    int eff;
    eff = (code < n_modes) ? code : n_modes - 1;
    return 2 << eff;
  endfunction

endpackage

// File: rtl/smul_seg_adder.sv
`timescale 1ns/1ps
// Ripple adder whose carry chain is cut at lane boundaries chosen by mode.
module smul_seg_adder
  import smul_pkg::*;
#(
  parameter int W  = 16,
  parameter int MW = 2
) (
  input  logic [MW-1:0]  mode,
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [W-1:0]   sum,
  output logic [W/2-1:0] lane_co
);
  localparam int NM   = $clog2(W);
  localparam int NSEL = 1 << MW;

  logic [W-1:0] ci;
  logic [W-1:0] co;

  for (genvar k = 0; k < W; k++) begin : g_bit
    logic [NSEL-1:0] start_c;
    logic            prev_co;

    for (genvar m = 0; m < NSEL; m++) begin : g_mode
      localparam int LW = lane_width(m, NM);
      assign start_c[m] = ((k % LW) == 0);
    end

    if (k == 0) begin : g_first
      assign prev_co = 1'b0;
    end else begin : g_chain
      assign prev_co = co[k-1];
    end

    // carry mux: a lane's least significant bit never sees a carry in
    assign ci[k]  = start_c[mode] ? 1'b0 : prev_co;
    assign sum[k] = x[k] ^ y[k] ^ ci[k];
    assign co[k]  = (x[k] & y[k]) | (ci[k] & (x[k] ^ y[k]));
  end

  // every lane top bit is odd; export only those carries
  for (genvar j = 0; j < W/2; j++) begin : g_laneco
    assign lane_co[j] = co[2*j+1];
  end

endmodule

// File: rtl/smul_lane_step.sv
`timescale 1ns/1ps
// One add-and-shift iteration applied lane-wise to the accumulator pair.
module smul_lane_step
  import smul_pkg::*;
#(
  parameter int W  = 16,
  parameter int MW = 2
) (
  input  logic [MW-1:0] mode,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  hi,
  input  logic [W-1:0]  lo,
  output logic [W-1:0]  hi_nx,
  output logic [W-1:0]  lo_nx
);
  localparam int NM   = $clog2(W);
  localparam int NSEL = 1 << MW;

  logic [W-1:0]   addend;
  logic [W-1:0]   sum;
  logic [W/2-1:0] lane_co;

  for (genvar k = 0; k < W; k++) begin : g_bit
    logic [NSEL-1:0] mbit_c;
    logic [NSEL-1:0] hi_c;
    logic [NSEL-1:0] lo_c;

    for (genvar m = 0; m < NSEL; m++) begin : g_mode
      localparam int LW  = lane_width(m, NM);
      localparam int LSB = k - (k % LW);
      localparam bit TOP = ((k % LW) == (LW - 1));

      // multiplier bit under test sits at the lane's low end
      assign mbit_c[m] = lo[LSB];

      if (TOP) begin : g_top
        assign hi_c[m] = lane_co[k/2];
        assign lo_c[m] = sum[LSB];
      end else begin : g_mid
        assign hi_c[m] = sum[k+1];
        assign lo_c[m] = lo[k+1];
      end
    end

    assign addend[k] = a[k] & mbit_c[mode];
    assign hi_nx[k]  = hi_c[mode];
    assign lo_nx[k]  = lo_c[mode];
  end

  smul_seg_adder #(
    .W  (W),
    .MW (MW)
  ) u_add (
    .mode    (mode),
    .x       (hi),
    .y       (addend),
    .sum     (sum),
    .lane_co (lane_co)
  );

endmodule

// File: rtl/smul_packer.sv
`timescale 1ns/1ps
// Interleaves the accumulator halves into per-lane double-width products.
module smul_packer
  import smul_pkg::*;
#(
  parameter int W  = 16,
  parameter int MW = 2
) (
  input  logic [MW-1:0]  mode,
  input  logic [W-1:0]   hi,
  input  logic [W-1:0]   lo,
  output logic [2*W-1:0] product
);
  localparam int NM   = $clog2(W);
  localparam int NSEL = 1 << MW;

  logic [2*W-1:0] packed_c [NSEL];

  for (genvar m = 0; m < NSEL; m++) begin : g_mode
    localparam int LW = lane_width(m, NM);
    for (genvar i = 0; i < W/LW; i++) begin : g_lane
      assign packed_c[m][2*LW*i +: 2*LW] = {hi[LW*i +: LW], lo[LW*i +: LW]};
    end
  end

  assign product = packed_c[mode];

endmodule

// File: rtl/smul_seq_ctrl.sv
`timescale 1ns/1ps
// Handshake and iteration sequencer.
module smul_seq_ctrl
  import smul_pkg::*;
#(
  parameter int W  = 16,
  parameter int MW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          out_ready,
  input  logic [MW-1:0] mode,
  output logic          in_ready,
  output logic          out_valid,
  output logic          done,
  output logic          load,
  output logic          step,
  output logic [MW-1:0] mode_q
);
  localparam int NM   = $clog2(W);
  localparam int NSEL = 1 << MW;
  localparam int CW   = $clog2(W) + 1;

  smul_state_e   st;
  logic [CW-1:0] cnt;
  logic          done_q;
  logic [CW-1:0] iters_c [NSEL];

  for (genvar m = 0; m < NSEL; m++) begin : g_iters
    assign iters_c[m] = CW'(lane_width(m, NM));
  end

  assign in_ready  = (st == ST_IDLE);
  assign load      = in_ready & in_valid;
  assign step      = (st == ST_RUN);
  assign out_valid = (st == ST_HOLD);
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      done_q <= 1'b0;
      mode_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (in_valid) begin
            st     <= ST_RUN;
            cnt    <= iters_c[mode];
            mode_q <= mode;
          end
        end
        ST_RUN: begin
          cnt <= cnt - CW'(1);
          if (cnt == CW'(1)) begin
            st     <= ST_HOLD;
            done_q <= 1'b1;
          end
        end
        ST_HOLD: begin
          if (out_ready) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Iterations observed since the last acceptance, for the latency check.
  logic [CW-1:0] seen_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    seen_len <= '0;
    else if (load) seen_len <= '0;
    else if (step) seen_len <= seen_len + CW'(1);
  end

  // R4
  run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (seen_len == iters_c[mode_q]));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!out_valid && !step));

  // R8
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

endmodule

// File: rtl/simd_shiftadd_mul.sv
`timescale 1ns/1ps
module simd_shiftadd_mul
  import smul_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [(($clog2($clog2(W)) > 0) ? $clog2($clog2(W)) : 1)-1:0] mode,
  input  logic                                    in_valid,
  output logic                                    in_ready,
  input  logic [W-1:0]                            a,
  input  logic [W-1:0]                            b,
  input  logic                                    out_ready,
  output logic                                    out_valid,
  output logic [2*W-1:0]                          product,
  output logic                                    done
);
  localparam int NM = $clog2(W);
  localparam int MW = ($clog2(NM) > 0) ? $clog2(NM) : 1;

  logic          load;
  logic          step;
  logic [MW-1:0] mode_q;
  logic [W-1:0]  a_q;
  logic [W-1:0]  hi_q;
  logic [W-1:0]  lo_q;
  logic [W-1:0]  hi_nx;
  logic [W-1:0]  lo_nx;

  smul_seq_ctrl #(
    .W  (W),
    .MW (MW)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .mode      (mode),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .done      (done),
    .load      (load),
    .step      (step),
    .mode_q    (mode_q)
  );

  // Accumulator: hi holds partial sums, lo holds unconsumed multiplier bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      hi_q <= '0;
      lo_q <= '0;
    end else if (load) begin
      a_q  <= a;
      hi_q <= '0;
      lo_q <= b;
    end else if (step) begin
      hi_q <= hi_nx;
      lo_q <= lo_nx;
    end
  end

  smul_lane_step #(
    .W  (W),
    .MW (MW)
  ) u_step (
    .mode  (mode_q),
    .a     (a_q),
    .hi    (hi_q),
    .lo    (lo_q),
    .hi_nx (hi_nx),
    .lo_nx (lo_nx)
  );

  smul_packer #(
    .W  (W),
    .MW (MW)
  ) u_pack (
    .mode    (mode_q),
    .hi      (hi_q),
    .lo      (lo_q),
    .product (product)
  );

  // R7
  mode_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(mode_q));

  // R7
  operand_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(a_q));

  // R8
  product_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(product));

endmodule

// File: tb/tb_simd_shiftadd_mul.sv
`timescale 1ns/1ps
module tb_simd_shiftadd_mul;
  localparam int W = 16;
  localparam real TCK = 8.0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  a = '0;
  logic [W-1:0]  b = '0;
  logic          out_ready = 1'b0;
  logic          out_valid;
  logic [2*W-1:0] product;
  logic          done;

  int n_run = 0;
  int n_fail = 0;

  always #(TCK/2) clk = ~clk;

  simd_shiftadd_mul #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid),
    .in_ready(in_ready), .a(a), .b(b), .out_ready(out_ready),
    .out_valid(out_valid), .product(product), .done(done)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected lane-wise unsigned product (R1, R2)
  function automatic logic [63:0] ref_prod(input logic [W-1:0] x,
                                           input logic [W-1:0] y,
                                           input logic [1:0] md);
    int n;
    logic [63:0] msk, r, xi, yi;
    n = 2 << md;
    msk = (64'd1 << n) - 64'd1;
    r = '0;
    for (int i = 0; i < W/n; i++) begin
      xi = (64'(x) >> (n*i)) & msk;
      yi = (64'(y) >> (n*i)) & msk;
      r = r | ((xi * yi) << (2*n*i));
    end
    return r;
  endfunction

  task automatic scramble();
    in_valid = 1'($urandom);
    a = W'($urandom);
    b = W'($urandom);
    mode = 2'($urandom);
  endtask

  task automatic run_one(input logic [W-1:0] xa, input logic [W-1:0] xb,
                         input logic [1:0] md, input int hold, input string tag);
    int n;
    logic [63:0] expv;
    logic [2*W-1:0] held;
    n = 2 << md;
    expv = ref_prod(xa, xb, md);
    @(negedge clk);
    chk(in_ready === 1'b1, "R6 in_ready idle", 64'(in_ready), 64'd1);
    in_valid = 1'b1; a = xa; b = xb; mode = md;
    @(posedge clk);
    @(negedge clk);
    scramble();
    chk(in_ready === 1'b0, "R6 in_ready busy", 64'(in_ready), 64'd0);
    for (int k = 1; k <= n; k++) begin
      @(posedge clk);
      @(negedge clk);
      scramble();
      if (k < n)
        chk(out_valid === 1'b0, "R4 early out_valid", 64'(out_valid), 64'd0);
      else begin
        chk(out_valid === 1'b1, "R4 out_valid at n", 64'(out_valid), 64'd1);
        chk(done === 1'b1, "R5 done with result", 64'(done), 64'd1);
      end
    end
    chk(64'(product) === expv, tag, 64'(product), expv);
    held = product;
    for (int h = 0; h < hold; h++) begin
      @(posedge clk);
      @(negedge clk);
      scramble();
      chk(out_valid === 1'b1, "R8 held out_valid", 64'(out_valid), 64'd1);
      chk(product === held, "R8 held product", 64'(product), 64'(held));
      chk(done === 1'b0, "R5 done single", 64'(done), 64'd0);
      chk(in_ready === 1'b0, "R6 no accept while holding", 64'(in_ready), 64'd0);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b0;
    chk(out_valid === 1'b0, "R8 drained", 64'(out_valid), 64'd0);
    chk(in_ready === 1'b1, "R8 ready after drain", 64'(in_ready), 64'd1);
    chk(done === 1'b0, "R5 done low after", 64'(done), 64'd0);
  endtask

  initial begin
    #(TCK * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(in_ready === 1'b1, "R9 reset in_ready", 64'(in_ready), 64'd1);
    chk(out_valid === 1'b0, "R9 reset out_valid", 64'(out_valid), 64'd0);
    chk(done === 1'b0, "R9 reset done", 64'(done), 64'd0);
    chk(product === '0, "R9 reset product", 64'(product), 64'd0);

    for (int m = 0; m < 4; m++) begin
      run_one('1, '1, 2'(m), 0, "R3 all-ones lanes");
      run_one('0, '1, 2'(m), 1, "R2 zero multiplicand");
      run_one(16'hAAAA, 16'h5555, 2'(m), 2, "R2 alternating bits");
      run_one(16'h0001, 16'hFFFF, 2'(m), 0, "R1 lane0 only");
      run_one(16'h8000, 16'h8000, 2'(m), 3, "R1 top lane only");
    end

    for (int t = 0; t < 150; t++) begin
      run_one(W'($urandom), W'($urandom), 2'($urandom), int'($urandom % 4),
              "R2 random lanes R7 inputs ignored");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule